// File: doc/BRIEF.md
# Four-Channel Joinable Audio Divider Network

This block is the timing core of a four-voice sound generator. Each voice has an 8-bit down-counter that reloads from a frequency byte and emits a one-cycle tick on each underflow. The ticks drive the distortion and waveform stages that follow. A single control byte picks the shared base rate. It can also clock the first and third voices straight from the system clock, fuse each pair of voices into one 16-bit divider, and insert a high-pass stage on the first two voices. The 9-bit poly mode bit passes through unchanged for the poly stage downstream.

A divider that has the system clock as its enable runs every cycle. A reload offset makes its period the frequency value plus 4 when it runs alone, or the 16-bit value plus 7 when it is joined. A shared prescaler produces base ticks every 28 or 114 system cycles. Each voice pair has a small state machine with two states, PAIR_SPLIT and PAIR_JOINED. The JOIN transition (SPLIT to JOINED) is taken when the pair's join bit is set, and the SPLIT transition (JOINED to SPLIT) when it is cleared. In the cycle of either transition, both counters of the pair restart from their reload values and no tick leaves the pair. Each high-pass stage stores the voice's waveform bit whenever its sampling voice ticks. Its filtered output is the exclusive-OR of the live waveform and that stored bit.

Top module: `audio_divider_net`

## Requirements
- R1: Control bit 0 low gives a base tick every 28 system cycles; high gives one every 114. Base ticks never fall in adjacent cycles.
- R2: A voice clocked by base ticks and not joined ticks once every (F+1) base ticks, where F is its frequency byte.
- R3: Control bit 6 clocks voice 0, and bit 5 clocks voice 2, on every system cycle. The period of either voice is then F+4 cycles, with F=0 giving 4 and F=255 giving 259.
- R4: Control bit 4 joins voices 0 and 1 into a divider with value V={freq1,freq0}. Voice 1 ticks every V+1 base ticks, and voice 0 never ticks while the pair is joined.
- R5: A joined pair whose low voice is clocked by the system clock has a period of V+7 cycles.
- R6: Control bit 3 joins voices 2 and 3, with V={freq3,freq2}. The tick comes out on voice 3 and voice 2 is muted.
- R7: In the cycle where a pair's join bit changes, neither voice of the pair ticks, even at a pending underflow. The first tick after the change comes one full new period later.
- R8: With control bit 2 set, high-pass bit 0 captures waveform bit 0 on each tick of voice 1 and holds it between ticks. Filtered output 0 is waveform 0 XOR that bit.
- R9: With control bit 1 set, high-pass bit 1 captures waveform bit 1 on each tick of voice 3. Filtered output 1 is waveform 1 XOR that bit.
- R10: With its enable bit clear, a high-pass bit reads 0 from the next cycle on, and the filtered output equals the waveform.
- R11: The poly mode output always equals control bit 7.
- R12: While reset is asserted with the control byte at 0, all ticks and high-pass bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_i | input | 8 | Control byte |
| freq0_i | input | 8 | Reload byte, voice 0 |
| freq1_i | input | 8 | Reload byte, voice 1 |
| freq2_i | input | 8 | Reload byte, voice 2 |
| freq3_i | input | 8 | Reload byte, voice 3 |
| wave_i | input | 2 | Waveform bits of voices 0 and 1 |
| tick_o | output | 4 | Per-voice underflow ticks |
| hp_o | output | 2 | Stored high-pass bits |
| filt_o | output | 2 | Filtered waveform bits |
| poly9_o | output | 1 | Poly mode select for downstream |

## Verification
The case that matters most is a pair's join bit flipping in the same cycle that its low counter underflows. The mode transition and the tick then compete for that one cycle. The bench waits until it sees voice 0 tick at a sampling point, then sets the join bit at that same instant. It requires both voice 0 and voice 1 to be silent in that cycle, and the first joined tick to arrive exactly V+7 cycles after the transition edge.

// File: rtl/adn_pkg.sv
package adn_pkg;
    typedef enum logic {
        PAIR_SPLIT  = 1'b0,
        PAIR_JOINED = 1'b1
    } pair_st_e;

    // control byte bit positions (decoded by this block)
    localparam int CB_SLOW   = 0;
    localparam int CB_HP_V1  = 1;
    localparam int CB_HP_V0  = 2;
    localparam int CB_JOIN_B = 3;
    localparam int CB_JOIN_A = 4;
    localparam int CB_FAST_B = 5;
    localparam int CB_FAST_A = 6;
    localparam int CB_POLY9  = 7;
endpackage

// File: rtl/adn_base.sv
module adn_base #(
    parameter int FAST_DIV = 28,
    parameter int SLOW_DIV = 114
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);
    localparam int CW = $clog2(SLOW_DIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim = slow_i ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= lim) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_BASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
endmodule

// File: rtl/adn_pair.sv
module adn_pair
    import adn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_lo_i,
    input  logic         en_hi_i,
    input  logic         fast_i,
    input  logic         join_i,
    input  logic [W-1:0] f_lo_i,
    input  logic [W-1:0] f_hi_i,
    output logic         tick_lo_o,
    output logic         tick_hi_o
);
    localparam int LW = W + 2;
    localparam int JW = 2 * W + 1;

    pair_st_e st_q, st_nxt;
    logic          switching;
    logic [LW-1:0] cnt_lo_q, reload_lo;
    logic [W-1:0]  cnt_hi_q;
    logic [JW-1:0] cnt_j_q, reload_j;

    always_comb begin
        st_nxt    = join_i ? PAIR_JOINED : PAIR_SPLIT;
        switching = (st_nxt != st_q);
        reload_lo = {2'b00, f_lo_i} + (fast_i ? LW'(3) : LW'(0));
        reload_j  = {1'b0, f_hi_i, f_lo_i} + (fast_i ? JW'(6) : JW'(0));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PAIR_SPLIT;
        else        st_q <= st_nxt;
    end

    // counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo_q <= '0;
            cnt_hi_q <= '0;
            cnt_j_q  <= '0;
        end else if (switching) begin
            cnt_lo_q <= reload_lo;
            cnt_hi_q <= f_hi_i;
            cnt_j_q  <= reload_j;
        end else begin
            unique case (st_q)
                PAIR_SPLIT: begin
                    if (en_lo_i) cnt_lo_q <= (cnt_lo_q == '0) ? reload_lo : cnt_lo_q - 1'b1;
                    if (en_hi_i) cnt_hi_q <= (cnt_hi_q == '0) ? f_hi_i : cnt_hi_q - 1'b1;
                end
                PAIR_JOINED: begin
                    if (en_lo_i) cnt_j_q <= (cnt_j_q == '0) ? reload_j : cnt_j_q - 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tick_lo_o = 1'b0;
        tick_hi_o = 1'b0;
        unique case (st_q)
            PAIR_SPLIT: begin
                tick_lo_o = !switching && en_lo_i && (cnt_lo_q == '0);
                tick_hi_o = !switching && en_hi_i && (cnt_hi_q == '0);
            end
            PAIR_JOINED: begin
                tick_hi_o = !switching && en_lo_i && (cnt_j_q == '0);
            end
        endcase
    end

    AST_JOIN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        join_i |-> !tick_lo_o); // R4
    AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(join_i) |-> (!tick_lo_o && !tick_hi_o)); // R7
    AST_FAST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_i && tick_lo_o) |=> !tick_lo_o); // R3
endmodule

// File: rtl/adn_hipass.sv
module adn_hipass (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic smp_i,
    input  logic wave_i,
    output logic hp_o,
    output logic filt_o
);
    logic hp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     hp_q <= 1'b0;
        else if (!en_i) hp_q <= 1'b0;
        else if (smp_i) hp_q <= wave_i;
    end

    always_comb begin
        hp_o   = hp_q;
        filt_o = en_i ? (wave_i ^ hp_q) : wave_i;
    end

    AST_HP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hp_q); // R10
    AST_HP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !smp_i) |=> (!en_i || $stable(hp_q))); // R8
endmodule

// File: rtl/audio_divider_net.sv
module audio_divider_net
    import adn_pkg::*;
#(
    parameter int W        = 8,
    parameter int FAST_DIV = 28,
    parameter int SLOW_DIV = 114
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   ctl_i,
    input  logic [W-1:0] freq0_i,
    input  logic [W-1:0] freq1_i,
    input  logic [W-1:0] freq2_i,
    input  logic [W-1:0] freq3_i,
    input  logic [1:0]   wave_i,
    output logic [3:0]   tick_o,
    output logic [1:0]   hp_o,
    output logic [1:0]   filt_o,
    output logic         poly9_o
);
    localparam int NPAIR = 2;
    localparam int NHP   = 2;

    logic         base_tick;
    logic [W-1:0] freq [4];

    always_comb begin
        freq[0] = freq0_i;
        freq[1] = freq1_i;
        freq[2] = freq2_i;
        freq[3] = freq3_i;
        poly9_o = ctl_i[CB_POLY9];
    end

    adn_base #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_base (
        .clk(clk), .rst_n(rst_n), .slow_i(ctl_i[CB_SLOW]), .tick_o(base_tick)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int FB = (p == 0) ? CB_FAST_A : CB_FAST_B;
        localparam int JB = (p == 0) ? CB_JOIN_A : CB_JOIN_B;
        logic lo_en;
        always_comb lo_en = ctl_i[FB] | base_tick;
        adn_pair #(.W(W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_lo_i  (lo_en),
            .en_hi_i  (base_tick),
            .fast_i   (ctl_i[FB]),
            .join_i   (ctl_i[JB]),
            .f_lo_i   (freq[2*p]),
            .f_hi_i   (freq[2*p+1]),
            .tick_lo_o(tick_o[2*p]),
            .tick_hi_o(tick_o[2*p+1])
        );
    end

    for (genvar h = 0; h < NHP; h++) begin : g_hp
        localparam int EB = (h == 0) ? CB_HP_V0 : CB_HP_V1;
        localparam int SV = (h == 0) ? 1 : 3;
        adn_hipass u_hp (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (ctl_i[EB]),
            .smp_i (tick_o[SV]),
            .wave_i(wave_i[h]),
            .hp_o  (hp_o[h]),
            .filt_o(filt_o[h])
        );
    end
endmodule

// File: tb/test_audio_divider_net.sv
`timescale 1ns/1ps
module test_audio_divider_net;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctl = 8'h00, f0 = 8'h00, f1 = 8'h00, f2 = 8'h00, f3 = 8'h00;
    logic [1:0] wave = 2'b00;
    logic [3:0] tick;
    logic [1:0] hp, filt;
    logic       poly9;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam int LIMIT = 40000;

    always #2.5 clk = ~clk;

    audio_divider_net i_audio_divider_net (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl),
        .freq0_i(f0), .freq1_i(f1), .freq2_i(f2), .freq3_i(f3),
        .wave_i(wave), .tick_o(tick), .hp_o(hp), .filt_o(filt), .poly9_o(poly9)
    );

    typedef struct packed {
        logic [7:0]  c, a0, a1, a2, a3;
        logic [1:0]  ch;
        logic [31:0] per;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1, 32'd28,  32'd1},  // R1 fast base
        '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1, 32'd114, 32'd1},  // R1 slow base
        '{8'h40, 8'h05, 8'h00, 8'h00, 8'h00, 2'd0, 32'd9,   32'd3},  // R3
        '{8'h20, 8'h00, 8'h00, 8'h0A, 8'h00, 2'd2, 32'd14,  32'd3},  // R3 voice 2
        '{8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 32'd4,   32'd3},  // R3 F=0
        '{8'h40, 8'hFF, 8'h00, 8'h00, 8'h00, 2'd0, 32'd259, 32'd3},  // R3 F=255
        '{8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 2'd0, 32'd112, 32'd2},  // R2
        '{8'h01, 8'h00, 8'h02, 8'h00, 8'h00, 2'd1, 32'd342, 32'd2},  // R2 slow
        '{8'h10, 8'h02, 8'h00, 8'h00, 8'h00, 2'd1, 32'd84,  32'd4},  // R4
        '{8'h50, 8'h10, 8'h01, 8'h00, 8'h00, 2'd1, 32'd279, 32'd5},  // R5
        '{8'h28, 8'h00, 8'h00, 8'h05, 8'h01, 2'd3, 32'd268, 32'd6},  // R6 fast
        '{8'h08, 8'h00, 8'h00, 8'h01, 8'h00, 2'd3, 32'd56,  32'd6}   // R6 base
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input int ch, output int n);
        n = 0;
        while (!tick[ch] && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    task automatic measure(input int ch, output int per);
        int n;
        @(negedge clk);
        wait_tick(ch, n);
        @(negedge clk);
        per = 1;
        while (!tick[ch] && per < LIMIT) begin @(negedge clk); per++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, n, cnt0, cnt1;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(tick == 4'b0 && hp == 2'b0, "R12", {hp, tick}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ctl = TBL[i].c; f0 = TBL[i].a0; f1 = TBL[i].a1; f2 = TBL[i].a2; f3 = TBL[i].a3;
            measure(int'(TBL[i].ch), per);
            check(per == int'(TBL[i].per), $sformatf("R%0d vec%0d", TBL[i].req, i), per, int'(TBL[i].per));
        end

        // R4 / R6: low voice muted while joined
        ctl = 8'h18; f0 = 8'h02; f1 = 8'h00; f2 = 8'h01; f3 = 8'h00;
        cnt0 = 0; cnt1 = 0;
        repeat (400) begin
            @(negedge clk);
            if (tick[0] || tick[2]) cnt0++;
            if (tick[1]) cnt1++;
        end
        check(cnt0 == 0, "R4 R6 mute", cnt0, 0);
        check(cnt1 > 0, "R4 high voice ticks", cnt1, 1);

        // R11 poly pass-through
        ctl = 8'h80; #1;
        check(poly9 == 1'b1, "R11 set", poly9, 1);
        ctl = 8'h00; #1;
        check(poly9 == 1'b0, "R11 clear", poly9, 0);

        // R7 join lands on an underflow cycle
        ctl = 8'h40; f0 = 8'h03; f1 = 8'h00;
        @(negedge clk);
        wait_tick(0, n);
        ctl = 8'h50; #1;
        check(tick[1:0] == 2'b00, "R7 quiet", tick[1:0], 0);
        n = 0;
        @(negedge clk); n++;
        while (!tick[1] && n < LIMIT) begin @(negedge clk); n++; end
        check(n == 10, "R7 restart period", n, 10);

        // R8 high-pass on voice 0, sampled by voice 1
        ctl = 8'h44; f1 = 8'h00; wave = 2'b01;
        @(negedge clk);
        wait_tick(1, n);
        @(negedge clk);
        check(hp[0] == 1'b1, "R8 capture", hp[0], 1);
        check(filt[0] == 1'b0, "R8 xor", filt[0], 0);
        wave = 2'b00; #1;
        check(filt[0] == 1'b1 && hp[0] == 1'b1, "R8 hold", {hp[0], filt[0]}, 3);
        wait_tick(1, n);
        @(negedge clk);
        check(hp[0] == 1'b0, "R8 recapture", hp[0], 0);

        // R9 high-pass on voice 1, sampled by voice 3
        ctl = 8'h02; f3 = 8'h00; wave = 2'b10;
        @(negedge clk);
        wait_tick(3, n);
        @(negedge clk);
        check(hp == 2'b10, "R9 capture", hp, 2);
        check(filt[1] == 1'b0, "R9 xor", filt[1], 0);

        // R10 disable clears and passes waveform
        ctl = 8'h00;
        @(negedge clk);
        check(hp[1] == 1'b0, "R10 clear", hp[1], 0);
        check(filt[1] == 1'b1, "R10 pass", filt[1], 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule